// File: doc/BRIEF.md
# Serial Receive FIFO with Level-Triggered Data-Ready Flag

This block is the receive store of a serial port. A deserializer pushes 16-bit words into a 16-entry first-in first-out buffer. Either a processor, through a simple register-style bus, or a DMA engine, through a single read strobe, takes the words out one at a time from the same data port.

A data-ready flag reports when the stored word count has reached a programmable level. The flag drives an interrupt line and a DMA request line, and each line is gated by its own enable. The flag sets on its own when the level is reached. How it clears depends on who drains the buffer:
- **DMA reads:** the flag drops by itself as soon as the count falls below the level.
- **Processor reads:** software must first read the flag as 1, and later write 0 to it once the count is below the level.

A flush control empties the buffer. An 8-bit mode narrows the returned data to its low byte.

Top module: `rx_wm_fifo`

## Requirements
- R1: With level setting N on `wm_level`, the threshold is N+1 words. `rdy_flag` is 1 after any clock edge at which the stored count becomes at least N+1.
- R2: A processor pop (`cpu_rd_data`) never clears `rdy_flag`. The flag clears when all of these hold: a status read (`cpu_rd_stat`) saw `rdy_flag`=1; a later status write (`cpu_wr_stat`) carries `cpu_wr_val`=0; the count after that edge is below the threshold.
- R3: These status writes leave `rdy_flag` unchanged: a write of 0 with no earlier read of 1 since the last clear; a write of 0 while the count is at or above the threshold; any write of 1.
- R4: A DMA pop (`dma_rd`) that leaves the count below the threshold clears `rdy_flag` at that edge, with no status write.
- R5: While `fifo_flush` is 1 at a clock edge, the edge empties the buffer (count 0) and clears `rdy_flag`, the handshake state and `ovr_flag`. Pushes and pops in that cycle are discarded.
- R6: After `rst_n` is low, `count` is 0, `rdy_flag`, `ovr_flag`, `irq` and `dma_req` are 0, and `rd_data` is 0.
- R7: `rd_data` shows the oldest stored word in the same cycle as a read strobe. When `byte_mode`=1, bits 15:8 read 0 and bits 7:0 hold the word's low byte.
- R8: `irq` equals `rdy_flag` AND `irq_en`. `dma_req` equals `rdy_flag` AND `dma_en`.
- R9: A push while the count is 16 and no pop occurs drops the word and sets `ovr_flag`. `ovr_flag` stays 1 until a flush or reset.
- R10: A pop while the count is 0 returns `rd_data`=0 and leaves the count and the read order unchanged.
- R11: Words are returned in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Deserializer word strobe |
| push_data | input | 16 | Deserialized word |
| cpu_rd_data | input | 1 | Processor read of the data port (pops one word) |
| cpu_rd_stat | input | 1 | Processor read of the status word |
| cpu_wr_stat | input | 1 | Processor write of the status word |
| cpu_wr_val | input | 1 | Value written to the ready flag |
| dma_rd | input | 1 | DMA read of the data port (pops one word) |
| fifo_flush | input | 1 | Empties the buffer and clears the flags |
| wm_level | input | 4 | Level setting N; threshold is N+1 |
| byte_mode | input | 1 | 1 selects 8-bit data length |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| rd_data | output | 16 | Data port read value |
| count | output | 5 | Stored word count |
| rdy_flag | output | 1 | Level-reached flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The assertions check four properties on every cycle:
- the count never exceeds the depth;
- a count at the threshold always leaves the flag set;
- a flag with no status write and no DMA read survives the next edge;
- a flush empties the buffer, and a full-buffer push raises the overrun bit.

Other behaviours depend on ordered histories, so only the bench scenarios can show them:
- the read-1-then-write-0 handshake;
- the ignored writes;
- the automatic clear by DMA after interleaved processor pops;
- word ordering and byte-mode masking.

// File: rtl/rx_wm_pkg.sv
package rx_wm_pkg;
  localparam int P_DW    = 16;
  localparam int P_DEPTH = 16;
  localparam int P_WMW   = 4;
  localparam int P_CW    = $clog2(P_DEPTH + 1);

  // Threshold count at which the ready flag sets: level setting + 1.
  function automatic logic [P_CW-1:0] thr_of(input logic [P_WMW-1:0] lvl);
    return P_CW'(lvl) + P_CW'(1);
  endfunction

  // Shape a stored word for the data port according to data length.
  function automatic logic [P_DW-1:0] shape_word(input logic [P_DW-1:0] w,
                                                 input logic narrow);
    logic [P_DW-1:0] m;
    m = narrow ? {{(P_DW-8){1'b0}}, 8'hFF} : '1;
    return w & m;
  endfunction
endpackage

// File: rtl/rx_wm_store.sv
module rx_wm_store
  import rx_wm_pkg::*;
#(
  parameter int DW    = P_DW,
  parameter int DEPTH = P_DEPTH,
  parameter int CW    = P_CW,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovr_evt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop & ~empty & ~flush;
  assign push_ok = push & (~full | pop_ok) & ~flush;
  assign ovr_evt = push & ~push_ok & ~flush;
  assign head    = empty ? '0 : mem[rp];

  always_comb begin
    count_nxt = count;
    if (flush) count_nxt = '0;
    else if (push_ok && !pop_ok) count_nxt = count + CW'(1);
    else if (!push_ok && pop_ok) count_nxt = count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      count <= count_nxt;
      if (flush) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
        if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end
endmodule

// File: rtl/rx_wm_flag.sv
module rx_wm_flag
  import rx_wm_pkg::*;
#(
  parameter int CW = P_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] count_nxt,
  input  logic [CW-1:0] thr,
  input  logic          dma_pop,
  input  logic          st_rd,
  input  logic          st_wr,
  input  logic          st_wval,
  output logic          flag
);
  logic armed;
  logic below;
  logic hs_clear;
  logic dma_clear;

  assign below     = (count_nxt < thr);
  assign hs_clear  = st_wr & ~st_wval & armed & below;
  assign dma_clear = dma_pop & below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (flush) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (!below)                       flag <= 1'b1;
      else if (hs_clear || dma_clear)   flag <= 1'b0;
      if (hs_clear || dma_clear)        armed <= 1'b0;
      else if (st_rd && flag)           armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_wm_fifo.sv
module rx_wm_fifo
  import rx_wm_pkg::*;
#(
  parameter int DW    = P_DW,
  parameter int DEPTH = P_DEPTH,
  parameter int WMW   = P_WMW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_valid,
  input  logic [DW-1:0]  push_data,
  input  logic           cpu_rd_data,
  input  logic           cpu_rd_stat,
  input  logic           cpu_wr_stat,
  input  logic           cpu_wr_val,
  input  logic           dma_rd,
  input  logic           fifo_flush,
  input  logic [WMW-1:0] wm_level,
  input  logic           byte_mode,
  input  logic           irq_en,
  input  logic           dma_en,
  output logic [DW-1:0]  rd_data,
  output logic [CW-1:0]  count,
  output logic           rdy_flag,
  output logic           ovr_flag,
  output logic           irq,
  output logic           dma_req
);
  logic [DW-1:0] head;
  logic [CW-1:0] count_nxt;
  logic [CW-1:0] thr;
  logic          pop_req;
  logic          push_ok, pop_ok, ovr_evt;

  assign pop_req = cpu_rd_data | dma_rd;
  assign thr     = CW'(thr_of(P_WMW'(wm_level)));

  rx_wm_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
    .push(push_valid), .wdata(push_data), .pop(pop_req),
    .head(head), .count(count), .count_nxt(count_nxt),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovr_evt(ovr_evt)
  );

  rx_wm_flag #(.CW(CW)) u_flag (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
    .count_nxt(count_nxt), .thr(thr), .dma_pop(dma_rd & pop_ok),
    .st_rd(cpu_rd_stat), .st_wr(cpu_wr_stat), .st_wval(cpu_wr_val),
    .flag(rdy_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovr_flag <= 1'b0;
    else if (fifo_flush) ovr_flag <= 1'b0;
    else if (ovr_evt)    ovr_flag <= 1'b1;
  end

  assign rd_data = pop_ok ? DW'(shape_word(P_DW'(head), byte_mode)) : '0;
  assign irq     = rdy_flag & irq_en;
  assign dma_req = rdy_flag & dma_en;
endmodule

// File: rtl/rx_wm_chk.sv
module rx_wm_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_flush,
  input logic          dma_rd,
  input logic          cpu_wr_stat,
  input logic          push_valid,
  input logic          pop_ok,
  input logic [CW-1:0] count,
  input logic [CW-1:0] thr,
  input logic          rdy_flag,
  input logic          ovr_flag
);
  a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r1_flag_at_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_flush && !pop_ok && count >= thr) |=> rdy_flag);

  a_r2_no_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_flag && !fifo_flush && !dma_rd && !cpu_wr_stat) |=> rdy_flag);

  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (count == '0 && !rdy_flag && !ovr_flag));

  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !pop_ok && !fifo_flush && count == CW'(DEPTH)) |=> ovr_flag);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !fifo_flush) |=> ovr_flag);
endmodule

bind rx_wm_fifo rx_wm_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_flush(fifo_flush), .dma_rd(dma_rd),
  .cpu_wr_stat(cpu_wr_stat), .push_valid(push_valid), .pop_ok(pop_ok),
  .count(count), .thr(thr), .rdy_flag(rdy_flag), .ovr_flag(ovr_flag)
);

// File: tb/rx_wm_fifo_tb.sv
module rx_wm_fifo_tb;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, cpu_rd_data = 0, cpu_rd_stat = 0, cpu_wr_stat = 0;
  logic cpu_wr_val = 0, dma_rd = 0, fifo_flush = 0, byte_mode = 0;
  logic irq_en = 0, dma_en = 0;
  logic [15:0] push_data = 0;
  logic [3:0]  wm_level = 4'd3;
  logic [15:0] rd_data;
  logic [4:0]  count;
  logic rdy_flag, ovr_flag, irq, dma_req;
  int n_run = 0, n_fail = 0;
  logic [15:0] got;

  always #2.5 clk = ~clk;

  rx_wm_fifo u_dut (.*);

  // op codes: 0 push, 1 cpu pop, 2 dma pop, 3 status read, 4 write 0, 5 write 1
  // entry: {op[2:0], data[15:0], exp_count[4:0], exp_flag}
  localparam logic [24:0] VEC [15] = '{
    {3'd0, 16'h1111, 5'd1, 1'b0},
    {3'd0, 16'h2222, 5'd2, 1'b0},
    {3'd0, 16'h3333, 5'd3, 1'b0},
    {3'd0, 16'h4444, 5'd4, 1'b1},   // R1 threshold 4 reached
    {3'd1, 16'h1111, 5'd3, 1'b1},   // R2 cpu pop keeps flag, R11 order
    {3'd4, 16'h0000, 5'd3, 1'b1},   // R3 write 0 without read of 1
    {3'd3, 16'h0000, 5'd3, 1'b1},   // arm handshake
    {3'd0, 16'h5555, 5'd4, 1'b1},
    {3'd4, 16'h0000, 5'd4, 1'b1},   // R3 write 0 while at level
    {3'd1, 16'h2222, 5'd3, 1'b1},
    {3'd5, 16'h0000, 5'd3, 1'b1},   // R3 write 1 no effect
    {3'd4, 16'h0000, 5'd3, 1'b0},   // R2 handshake clears
    {3'd0, 16'h6666, 5'd4, 1'b1},
    {3'd2, 16'h3333, 5'd3, 1'b0},   // R4 dma clears automatically
    {3'd2, 16'h4444, 5'd2, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One operation: drive at negedge, capture rd_data, clock, deassert.
  task automatic op(input logic [2:0] o, input logic [15:0] d);
    @(negedge clk);
    push_valid  = (o == 3'd0);
    push_data   = d;
    cpu_rd_data = (o == 3'd1);
    dma_rd      = (o == 3'd2);
    cpu_rd_stat = (o == 3'd3);
    cpu_wr_stat = (o == 3'd4) || (o == 3'd5);
    cpu_wr_val  = (o == 3'd5);
    #1 got = rd_data;
    @(posedge clk);
    #1;
    push_valid = 0; cpu_rd_data = 0; dma_rd = 0;
    cpu_rd_stat = 0; cpu_wr_stat = 0; cpu_wr_val = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); fifo_flush = 1;
    @(posedge clk); #1 fifo_flush = 0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #12;
    chk("R6 count", 32'(count), 0);
    chk("R6 flags", {rdy_flag, ovr_flag, irq, dma_req}, 0);
    chk("R6 rd_data", 32'(rd_data), 0);
    rst_n = 1;

    for (int i = 0; i < 15; i++) begin
      op(VEC[i][24:22], VEC[i][21:6]);
      @(negedge clk);
      if (VEC[i][24:22] == 3'd1 || VEC[i][24:22] == 3'd2)
        chk($sformatf("R11 data step %0d", i), 32'(got), 32'(VEC[i][21:6]));
      chk($sformatf("R1-flow count step %0d", i), 32'(count), 32'(VEC[i][5:1]));
      chk($sformatf("R2/R3/R4 flag step %0d", i), 32'(rdy_flag), 32'(VEC[i][0]));
    end

    // R5 flush
    op(3'd0, 16'h7777); op(3'd0, 16'h8888);
    do_flush();
    @(negedge clk);
    chk("R5 count", 32'(count), 0);
    chk("R5 flag", 32'(rdy_flag), 0);

    // R10 empty read
    op(3'd1, 16'h0);
    chk("R10 rd_data", 32'(got), 0);
    chk("R10 count", 32'(count), 0);
    op(3'd0, 16'hA1B2);
    op(3'd1, 16'h0);
    chk("R10 order kept", 32'(got), 32'hA1B2);

    // R7 byte mode
    byte_mode = 1;
    op(3'd0, 16'hC3D4);
    op(3'd1, 16'h0);
    chk("R7 byte", 32'(got), 32'h00D4);
    byte_mode = 0;

    // R8 irq / dma_req gating, level 0 -> threshold 1
    wm_level = 4'd0;
    op(3'd0, 16'h0001);
    @(negedge clk);
    chk("R8 irq off", {irq, dma_req}, 0);
    irq_en = 1; #1;
    chk("R8 irq on", {irq, dma_req}, 2'b10);
    dma_en = 1; irq_en = 0; #1;
    chk("R8 dma on", {irq, dma_req}, 2'b01);
    dma_en = 0;
    op(3'd2, 16'h0);
    chk("R4 level0 dma clear", 32'(rdy_flag), 0);

    // R9 overrun
    wm_level = 4'd15;
    for (int k = 0; k < 16; k++) op(3'd0, 16'(k + 16'h100));
    chk("R1 level15 flag", 32'(rdy_flag), 1);
    chk("R9 no ovr yet", 32'(ovr_flag), 0);
    op(3'd0, 16'hDEAD);
    chk("R9 ovr set", 32'(ovr_flag), 1);
    chk("R9 count held", 32'(count), 16);
    op(3'd1, 16'h0);
    chk("R9 head kept", 32'(got), 32'h0100);
    chk("R9 ovr sticky", 32'(ovr_flag), 1);
    for (int k = 1; k < 16; k++) op(3'd1, 16'h0);
    chk("R9 last word not dropped one", 32'(got), 32'h010F);
    chk("R5 pre-flush ovr", 32'(ovr_flag), 1);
    do_flush();
    @(negedge clk);
    chk("R5 ovr cleared", 32'(ovr_flag), 0);

    // R6 reset mid-run
    op(3'd0, 16'h1234);
    rst_n = 0; #3;
    chk("R6 async reset count", 32'(count), 0);
    rst_n = 1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule